// File: doc/BRIEF.md
# Subsecond Real-Time Counter with Match and Rate Trim

This block keeps time from a 32.768 kHz tick. It holds a 15-bit subsecond count and a 32-bit seconds count, and the two together form a 47-bit timestamp. The tick arrives as a single-cycle qualifier `tick_i` in the system clock domain. The subsecond count advances on every tick. When it rolls over, the seconds count advances.

A signed trim value changes the length of one second in every 64. This lets software correct a crystal that runs fast or slow without touching the oscillator.

Software loads the seconds count, a seconds/subseconds match pair and the trim value through one write port. When the running count reaches the match pair, the block raises a sticky interrupt flag. If wake is enabled, it also gives a one-cycle wake pulse that a power controller can use.

Top module: `subsec_rtc`

## Requirements
- R1: While `rst_ni` is low, the block resets. After reset, `sec_o`, `subsec_o`, `irq_o` and `wake_o` are all zero, and the match and trim values are zero.
- R2: In a clock cycle with `tick_i` high, `subsec_o` rises by one. With `tick_i` low it holds. In an untrimmed second, `subsec_o` goes from 0x7FFF to 0 and `sec_o` rises by one in the same edge, so one second lasts 32768 ticks.
- R3: `sec_o` wraps from 0xFFFFFFFF to 0 on a rollover, with no other effect.
- R4: A write with `wr_sel_i` = 0 loads `wr_data_i` into `sec_o` and forces `subsec_o` to 0. The write overrides a tick in the same cycle.
- R5: A write with `wr_sel_i` = 3 stores `wr_data_i[7:0]` as a signed trim value t. The second in which `sec_o[5:0]` is 6'b111111 lasts 32768 + t ticks. Every other second lasts 32768 ticks, whatever t is.
- R6: A write with `wr_sel_i` = 1 sets the match seconds value. A write with `wr_sel_i` = 2 sets the match subseconds value from `wr_data_i[14:0]`. `irq_o` goes high on the edge of a tick cycle in which `sec_o` and `subsec_o` both equal the match pair. A difference in either field leaves `irq_o` low.
- R7: Once set, `irq_o` stays high until a cycle with `irq_clr_i` high clears it. If a match occurs in that same cycle, the match wins.
- R8: `wake_o` pulses high for one cycle on each match event while `wake_en_i` is high. It stays low on a match while `wake_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz count qualifier, one clock per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 seconds, 1 match seconds, 2 match subseconds, 3 trim |
| wr_data_i | input | 32 | Write data |
| irq_clr_i | input | 1 | Clears the match flag |
| wake_en_i | input | 1 | Enables the wake pulse on a match |
| sec_o | output | 32 | Seconds count |
| subsec_o | output | 15 | Subseconds count |
| irq_o | output | 1 | Sticky match flag |
| wake_o | output | 1 | One-cycle wake pulse on a match |

## Verification
The assertions assume the following about the inputs:
- `tick_i` is a clean clock-enable in the system clock domain.
- At most one register write occurs per cycle.
- Every input is held at a known level from time zero.

The stimulus meets these assumptions. It drives every input from tasks on the falling edge. It starts each case from a seconds write, so the subsecond count is always known. For positive trim, the count stays at 0x7FFF for extra ticks, so a match on that value could fire more than once. The match vectors avoid that value, which keeps the expected flag and wake-pulse counts exact.

// File: rtl/subsec_rtc_pkg.sv
package subsec_rtc_pkg;
  typedef enum logic [1:0] {
    SEL_SEC  = 2'd0,
    SEL_MSEC = 2'd1,
    SEL_MSUB = 2'd2,
    SEL_TRIM = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/subsec_rtc_prescale.sv
module subsec_rtc_prescale #(
  parameter int SUB_W  = 15,
  parameter int TRIM_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic              trim_sec_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic [SUB_W-1:0]  subsec_o,
  output logic              roll_o
);
  localparam logic [SUB_W-1:0] SUB_MAX = '1;

  logic [SUB_W-1:0]  sub_q;
  logic [TRIM_W-1:0] ext_q;
  logic [SUB_W-1:0]  term;
  logic              trim_neg, hold_need, at_term;

  assign trim_neg = trim_i[TRIM_W-1];
  // negative trim shortens the second; positive trim holds at the top value
  always_comb begin
    term = SUB_MAX;
    if (trim_sec_i && trim_neg)
      term = SUB_MAX + {{(SUB_W-TRIM_W){trim_i[TRIM_W-1]}}, trim_i};
  end
  assign hold_need = trim_sec_i && !trim_neg && (ext_q < trim_i);
  assign at_term   = (sub_q == term);
  assign roll_o    = tick_i && !load_i && at_term && !hold_need;
  assign subsec_o  = sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      ext_q <= '0;
    end else if (load_i) begin
      sub_q <= '0;
      ext_q <= '0;
    end else if (tick_i) begin
      if (at_term && hold_need) begin
        ext_q <= ext_q + 1'b1;
      end else if (at_term) begin
        sub_q <= '0;
        ext_q <= '0;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  p_subsec_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(sub_q));
  p_roll_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_o |=> (sub_q == '0));
  p_load_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sub_q == '0 && ext_q == '0));
endmodule

// File: rtl/subsec_rtc_seconds.sv
module subsec_rtc_seconds #(
  parameter int SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_val_i,
  input  logic             roll_i,
  output logic [SEC_W-1:0] sec_o
);
  logic [SEC_W-1:0] sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sec_q <= '0;
    else if (load_i) sec_q <= load_val_i;
    else if (roll_i) sec_q <= sec_q + 1'b1; // wraps silently
  end
  assign sec_o = sec_q;

  p_sec_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !roll_i) |=> $stable(sec_q));
  p_sec_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && roll_i) |=> (sec_q == $past(sec_q) + 1'b1));
endmodule

// File: rtl/subsec_rtc_match.sv
module subsec_rtc_match #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SUB_W-1:0] subsec_i,
  input  logic [SEC_W-1:0] match_sec_i,
  input  logic [SUB_W-1:0] match_sub_i,
  input  logic             clr_i,
  input  logic             wake_en_i,
  output logic             irq_o,
  output logic             wake_o
);
  logic hit, irq_q, wake_q;

  assign hit = tick_i && (sec_i == match_sec_i) && (subsec_i == match_sub_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= hit && wake_en_i;
      if (hit)        irq_q <= 1'b1; // set wins over clear
      else if (clr_i) irq_q <= 1'b0;
    end
  end
  assign irq_o  = irq_q;
  assign wake_o = wake_q;

  p_irq_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q);
  p_irq_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !irq_q);
  p_wake_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> irq_o);
  p_wake_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !wake_o);
endmodule

// File: rtl/subsec_rtc.sv
module subsec_rtc
  import subsec_rtc_pkg::*;
#(
  parameter int SEC_W      = 32,
  parameter int SUB_W      = 15,
  parameter int TRIM_W     = 8,
  parameter int TRIM_LOG2  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [31:0]      wr_data_i,
  input  logic             irq_clr_i,
  input  logic             wake_en_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] subsec_o,
  output logic             irq_o,
  output logic             wake_o
);
  logic [SEC_W-1:0]  match_sec_q;
  logic [SUB_W-1:0]  match_sub_q;
  logic [TRIM_W-1:0] trim_q;
  logic              load_sec, roll, trim_sec;

  assign load_sec = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_SEC);
  assign trim_sec = &sec_o[TRIM_LOG2-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_sec_q <= '0;
      match_sub_q <= '0;
      trim_q      <= '0;
    end else if (wr_en_i) begin
      case (wr_sel_e'(wr_sel_i))
        SEL_MSEC: match_sec_q <= wr_data_i[SEC_W-1:0];
        SEL_MSUB: match_sub_q <= wr_data_i[SUB_W-1:0];
        SEL_TRIM: trim_q      <= wr_data_i[TRIM_W-1:0];
        default:  ;
      endcase
    end
  end

  subsec_rtc_prescale #(.SUB_W(SUB_W), .TRIM_W(TRIM_W)) u_prescale (
    .clk_i, .rst_ni, .tick_i,
    .load_i(load_sec), .trim_sec_i(trim_sec), .trim_i(trim_q),
    .subsec_o, .roll_o(roll)
  );

  subsec_rtc_seconds #(.SEC_W(SEC_W)) u_seconds (
    .clk_i, .rst_ni, .load_i(load_sec), .load_val_i(wr_data_i[SEC_W-1:0]),
    .roll_i(roll), .sec_o
  );

  subsec_rtc_match #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_match (
    .clk_i, .rst_ni, .tick_i, .sec_i(sec_o), .subsec_i(subsec_o),
    .match_sec_i(match_sec_q), .match_sub_i(match_sub_q),
    .clr_i(irq_clr_i), .wake_en_i, .irq_o, .wake_o
  );

  p_load_sec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_sec |=> (subsec_o == '0 && sec_o == $past(wr_data_i[SEC_W-1:0])));
endmodule

// File: tb/subsec_rtc_bench.sv
module subsec_rtc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0, irq_clr = 1'b0, wake_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] sec;
  logic [14:0] subsec;
  logic        irq, wake;
  int          n_run = 0, n_fail = 0, wake_cnt = 0, cyc = 0;

  always #2.5 clk = ~clk;

  subsec_rtc u_subsec_rtc (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .irq_clr_i(irq_clr),
    .wake_en_i(wake_en), .sec_o(sec), .subsec_o(subsec), .irq_o(irq),
    .wake_o(wake)
  );

  always @(negedge clk) begin
    cyc++;
    if (wake) wake_cnt++;
  end

  // match vectors: load seconds, match pair, ticks to run, expected flag
  localparam int NV = 6;
  localparam logic [31:0] V_SEC  [NV] = '{32'd100, 32'd100, 32'd100, 32'hDEADBEEF, 32'd7, 32'd7};
  localparam logic [31:0] V_MSEC [NV] = '{32'd100, 32'd100, 32'd101, 32'hDEADBEEF, 32'd7, 32'd7};
  localparam logic [14:0] V_MSUB [NV] = '{15'd10, 15'd10, 15'd10, 15'd0, 15'd300, 15'd300};
  localparam int          V_N    [NV] = '{11, 10, 11, 1, 200, 301};
  localparam logic        V_IRQ  [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run_ticks(int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n - 1) @(negedge clk);
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sec", sec, 0);
    check("R1 subsec", {17'd0, subsec}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 wake", {31'd0, wake}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr(2'd1, V_MSEC[i]);
      wr(2'd2, {17'd0, V_MSUB[i]});
      wr(2'd0, V_SEC[i]);
      clear_irq();
      run_ticks(V_N[i]);
      @(negedge clk);
      check("R6 irq", {31'd0, irq}, {31'd0, V_IRQ[i]});
      check("R2 subsec", {17'd0, subsec}, V_N[i]);
      check("R2 sec", sec, V_SEC[i]);
    end

    // R7: sticky while ticks continue, then cleared
    run_ticks(20);
    check("R7 sticky", {31'd0, irq}, 1);
    clear_irq();
    check("R7 clear", {31'd0, irq}, 0);

    // R8: wake pulse only when enabled
    wake_en = 1'b0;
    wr(2'd1, 32'd5); wr(2'd2, 32'd3); wr(2'd0, 32'd5);
    wake_cnt = 0;
    run_ticks(8);
    repeat (2) @(negedge clk);
    check("R8 wake disabled", wake_cnt, 0);
    clear_irq();
    wake_en = 1'b1;
    wr(2'd0, 32'd5);
    wake_cnt = 0;
    run_ticks(8);
    repeat (2) @(negedge clk);
    check("R8 wake pulses", wake_cnt, 1);
    wake_en = 1'b0;

    // R4: seconds write overrides a tick in the same cycle
    run_ticks(4);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h1234;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    check("R4 subsec cleared", {17'd0, subsec}, 0);
    check("R4 sec loaded", sec, 32'h1234);

    // R2/R5: untrimmed second ignores a nonzero trim
    wr(2'd3, 32'd5);
    wr(2'd0, 32'd10);
    run_ticks(32767);
    check("R5 no trim sec", sec, 10);
    check("R5 no trim subsec", {17'd0, subsec}, 32'h7FFF);
    run_ticks(1);
    check("R2 rollover sec", sec, 11);
    check("R2 rollover subsec", {17'd0, subsec}, 0);

    // R5: positive trim lengthens second 63
    wr(2'd0, 32'd63);
    run_ticks(32772);
    check("R5 +trim early", sec, 63);
    run_ticks(1);
    check("R5 +trim end", sec, 64);

    // R5: negative trim shortens second 63
    wr(2'd3, 32'h0000_00FB);
    wr(2'd0, 32'd63);
    run_ticks(32762);
    check("R5 -trim early", sec, 63);
    run_ticks(1);
    check("R5 -trim end", sec, 64);

    // R3: seconds wrap
    wr(2'd3, 32'd0);
    wr(2'd0, 32'hFFFF_FFFF);
    run_ticks(32768);
    check("R3 wrap sec", sec, 0);
    check("R3 wrap subsec", {17'd0, subsec}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= 199000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule